// File: doc/BRIEF.md
# VGA Framebuffer Scanout Controller

This block produces the horizontal and vertical sync pulses of a raster display and streams 8-bit pixel bytes, one per pixel clock, from a framebuffer read port to a pixel output. A free-running counter divides time into lines. A line counter, stepped once per line, moves the vertical timing through four phases in a fixed order: back porch, visible, front porch and vertical sync. After vertical sync it returns to back porch.

During the visible phase each displayed line is read from the framebuffer in two equal halves. The second half starts at the line address plus half the line length. Each stored line can be shown on several consecutive display lines through a line multiplier. The line address wraps inside a circular screen region, so moving the screen start address scrolls the picture. Zero pixels surround the active data on every line, and no framebuffer data appears outside the visible phase. All timing and addressing values are parameters.

Top module: `vga_scanout`

## Requirements
- R1: While reset is asserted, hsync_n and vsync_n are 1, pixel is 0 and fb_rd_en is 0. After reset the horizontal position is 0 and the vertical phase is back porch with line count 0.
- R2: The horizontal position counts 0 to H_TOTAL-1 and then wraps. hsync_n is 0 exactly at positions HS_START up to HS_END-1 and 1 at all other positions.
- R3: The line count increments each time the horizontal position wraps. The phases run in the order back porch, visible, front porch, vertical sync. The change from back porch to visible happens when the new count is at least VIS_START. The change to front porch happens when it reaches VFP_START. The change to vertical sync happens when it is at least VS_START. When it is at least VS_END, the count is cleared to 0 and the phase returns to back porch.
- R4: vsync_n goes to 0 at the first line start after the phase becomes vertical sync. It goes back to 1 at the first line start after the phase leaves vertical sync. vsync_n changes only when the horizontal position is 0.
- R5: On the change to the visible phase, the line address is loaded with SCR_START.
- R6: On each later line start in the visible phase, the line address advances by LINE_LEN only if the new line count is an exact multiple of LINE_MULT. Otherwise the previous line is repeated. The line address changes only at a line start.
- R7: If an advanced line address is greater than or equal to SCR_LIMIT, SCR_SIZE is subtracted from it. The line address always stays below SCR_LIMIT.
- R8: On a visible line with line address A, pixel k for k below LINE_LEN/2 is the byte at A+k. Pixel LINE_LEN/2+j is the byte at A+LINE_LEN/2+j.
- R9: Pixel is 0 at positions below PAD_LEAD and at positions of PAD_LEAD+LINE_LEN and above, and on every line outside the visible phase. fb_rd_en stays 0 outside the visible phase.
- R10: The framebuffer returns data one cycle after a request. fb_rd_en is 1 at positions PAD_LEAD-1 to PAD_LEAD+LINE_LEN-2 of a visible line. The byte requested at position p is output as pixel at position p+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_rdata | input | 8 | Framebuffer read data, one cycle after the request |
| fb_rd_en | output | 1 | Framebuffer read request |
| fb_addr | output | ADDR_W | Framebuffer byte address of the request |
| pixel | output | 8 | Pixel byte, zero outside active data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
Sync outputs and read requests depend combinationally on the registered position, so they are due in the same cycle as the position they belong to. A pixel is due one cycle after its request, because of the read latency. The line address and vsync level take effect in the cycle in which the position returns to 0. The bench updates its behavioural model on the same clock edge as the design and compares every output at the falling edge, so each expected value is lined up with the registered position that produces it. Directed counts at the end confirm that a wrapped line address was displayed and that the expected number of vsync pulses occurred.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

    typedef enum logic [1:0] {
        PH_BPORCH = 2'd0,
        PH_VISIBLE = 2'd1,
        PH_FPORCH = 2'd2,
        PH_VSYNC = 2'd3
    } vphase_e;

    localparam int PIX_W = 8;

endpackage

// File: rtl/vga_hline_timer.sv
module vga_hline_timer #(
    parameter int H_TOTAL  = 32,
    parameter int HS_START = 26,
    parameter int HS_END   = 30,
    localparam int HW = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic          line_tick,
    output logic          hsync_n
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] HS_S   = HW'(HS_START);
    localparam logic [HW-1:0] HS_E   = HW'(HS_END);

    typedef struct packed {
        logic [HW-1:0] pos;
    } hstate_t;

    hstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pos == H_LAST) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_cnt     = st_q.pos;
    assign line_tick = rst_n && (st_q.pos == H_LAST);
    assign hsync_n   = !rst_n || !((st_q.pos >= HS_S) && (st_q.pos < HS_E));

endmodule

// File: rtl/vga_vframe_seq.sv
module vga_vframe_seq
    import vga_scan_pkg::*;
#(
    parameter int VIS_START = 3,
    parameter int VFP_START = 14,
    parameter int VS_START  = 16,
    parameter int VS_END    = 18,
    parameter int LINE_LEN  = 16,
    parameter int LINE_MULT = 2,
    parameter int SCR_START = 40,
    parameter int SCR_LIMIT = 88,
    parameter int SCR_SIZE  = 64,
    parameter int ADDR_W    = 12,
    localparam int LW = $clog2(VS_END + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    output logic              streaming,
    output logic              vsync_n,
    output logic [ADDR_W-1:0] line_addr
);
    localparam logic [LW-1:0]     L_VIS = LW'(VIS_START);
    localparam logic [LW-1:0]     L_VFP = LW'(VFP_START);
    localparam logic [LW-1:0]     L_VSS = LW'(VS_START);
    localparam logic [LW-1:0]     L_VSE = LW'(VS_END);
    localparam logic [ADDR_W:0]   A_LEN = (ADDR_W+1)'(LINE_LEN);
    localparam logic [ADDR_W:0]   A_LIM = (ADDR_W+1)'(SCR_LIMIT);
    localparam logic [ADDR_W:0]   A_SZ  = (ADDR_W+1)'(SCR_SIZE);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(SCR_START);

    typedef struct packed {
        vphase_e         phase;
        logic [LW-1:0]   line;
        logic [ADDR_W-1:0] addr;
        logic            vs_n;
    } vstate_t;

    vstate_t st_d, st_q;
    logic [LW-1:0]   line_inc;
    logic [ADDR_W:0] addr_step;
    logic [ADDR_W:0] addr_wrap;
    logic            on_multiple;

    always_comb begin
        line_inc    = st_q.line + 1'b1;
        on_multiple = ((32'(line_inc) % LINE_MULT) == 0);
        addr_step   = {1'b0, st_q.addr} + A_LEN;
        addr_wrap   = (addr_step >= A_LIM) ? (addr_step - A_SZ) : addr_step;

        st_d = st_q;
        if (line_tick) begin
            st_d.line = line_inc;
            st_d.vs_n = (st_q.phase != PH_VSYNC);
            unique case (st_q.phase)
                PH_BPORCH: begin
                    if (line_inc >= L_VIS) begin
                        st_d.phase = PH_VISIBLE;
                        st_d.addr  = A_START;
                    end
                end
                PH_VISIBLE: begin
                    if (line_inc < L_VFP) begin
                        if (on_multiple) begin
                            st_d.addr = addr_wrap[ADDR_W-1:0];
                        end
                    end else begin
                        st_d.phase = PH_FPORCH;
                    end
                end
                PH_FPORCH: begin
                    if (line_inc >= L_VSS) begin
                        st_d.phase = PH_VSYNC;
                    end
                end
                PH_VSYNC: begin
                    if (line_inc >= L_VSE) begin
                        st_d.line  = '0;
                        st_d.phase = PH_BPORCH;
                    end
                end
                default: st_d.phase = PH_BPORCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_BPORCH;
            st_q.line  <= '0;
            st_q.addr  <= A_START;
            st_q.vs_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign streaming = (st_q.phase == PH_VISIBLE);
    assign vsync_n   = st_q.vs_n;
    assign line_addr = st_q.addr;

endmodule

// File: rtl/vga_line_fetch.sv
module vga_line_fetch
    import vga_scan_pkg::*;
#(
    parameter int H_TOTAL  = 32,
    parameter int PAD_LEAD = 4,
    parameter int LINE_LEN = 16,
    parameter int ADDR_W   = 12,
    localparam int HW   = $clog2(H_TOTAL),
    localparam int HALF = LINE_LEN / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HW-1:0]     h_cnt,
    input  logic              streaming,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [PIX_W-1:0]  fb_rdata,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [PIX_W-1:0]  pixel
);
    localparam logic [HW-1:0]     REQ_FIRST = HW'(PAD_LEAD - 1);
    localparam logic [HW-1:0]     REQ_END   = HW'(PAD_LEAD - 1 + LINE_LEN);
    localparam logic [HW-1:0]     H_HALF    = HW'(HALF);
    localparam logic [ADDR_W-1:0] A_HALF    = ADDR_W'(HALF);

    typedef struct packed {
        logic valid;
    } fstate_t;

    fstate_t st_d, st_q;
    logic [HW-1:0]     idx;
    logic              second_half;
    logic [ADDR_W-1:0] half_base;
    logic [ADDR_W-1:0] half_off;

    always_comb begin
        idx         = h_cnt - REQ_FIRST;
        second_half = (idx >= H_HALF);
        half_base   = second_half ? (line_addr + A_HALF) : line_addr;
        half_off    = second_half ? ADDR_W'(idx - H_HALF) : ADDR_W'(idx);
        fb_rd_en    = streaming && (h_cnt >= REQ_FIRST) && (h_cnt < REQ_END);
        fb_addr     = fb_rd_en ? (half_base + half_off) : '0;
        st_d.valid  = fb_rd_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pixel = st_q.valid ? fb_rdata : '0;

endmodule

// File: rtl/vga_scanout.sv
module vga_scanout
    import vga_scan_pkg::*;
#(
    parameter int H_TOTAL   = 32,
    parameter int HS_START  = 26,
    parameter int HS_END    = 30,
    parameter int PAD_LEAD  = 4,
    parameter int VIS_START = 3,
    parameter int VFP_START = 14,
    parameter int VS_START  = 16,
    parameter int VS_END    = 18,
    parameter int LINE_LEN  = 16,
    parameter int LINE_MULT = 2,
    parameter int SCR_START = 40,
    parameter int SCR_LIMIT = 88,
    parameter int SCR_SIZE  = 64,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        fb_rdata,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [7:0]        pixel,
    output logic              hsync_n,
    output logic              vsync_n
);
    localparam int HW = $clog2(H_TOTAL);

    logic [HW-1:0]     h_cnt;
    logic              line_tick;
    logic              streaming;
    logic [ADDR_W-1:0] line_addr;

    vga_hline_timer #(
        .H_TOTAL (H_TOTAL),
        .HS_START(HS_START),
        .HS_END  (HS_END)
    ) u_htimer (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_cnt    (h_cnt),
        .line_tick(line_tick),
        .hsync_n  (hsync_n)
    );

    vga_vframe_seq #(
        .VIS_START(VIS_START),
        .VFP_START(VFP_START),
        .VS_START (VS_START),
        .VS_END   (VS_END),
        .LINE_LEN (LINE_LEN),
        .LINE_MULT(LINE_MULT),
        .SCR_START(SCR_START),
        .SCR_LIMIT(SCR_LIMIT),
        .SCR_SIZE (SCR_SIZE),
        .ADDR_W   (ADDR_W)
    ) u_vseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_tick(line_tick),
        .streaming(streaming),
        .vsync_n  (vsync_n),
        .line_addr(line_addr)
    );

    vga_line_fetch #(
        .H_TOTAL (H_TOTAL),
        .PAD_LEAD(PAD_LEAD),
        .LINE_LEN(LINE_LEN),
        .ADDR_W  (ADDR_W)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_cnt    (h_cnt),
        .streaming(streaming),
        .line_addr(line_addr),
        .fb_rdata (fb_rdata),
        .fb_rd_en (fb_rd_en),
        .fb_addr  (fb_addr),
        .pixel    (pixel)
    );

endmodule

// File: rtl/vga_scanout_chk.sv
module vga_scanout_chk #(
    parameter int H_TOTAL   = 32,
    parameter int HS_START  = 26,
    parameter int SCR_LIMIT = 88,
    parameter int ADDR_W    = 12,
    localparam int HW = $clog2(H_TOTAL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fb_rd_en,
    input logic [7:0]        pixel,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic [HW-1:0]     h_cnt,
    input logic [ADDR_W-1:0] line_addr
);
    AST_HS_FALL_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> (32'(h_cnt) == HS_START)); // R2

    AST_VS_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsync_n) |-> (h_cnt == '0)); // R4

    AST_ADDR_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt != '0) |-> $stable(line_addr)); // R6

    AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(line_addr) < SCR_LIMIT)); // R7

    AST_PIX_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fb_rd_en) |-> (pixel == 8'd0)); // R9

    AST_NO_FETCH_IN_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !fb_rd_en); // R9

endmodule

bind vga_scanout vga_scanout_chk #(
    .H_TOTAL  (H_TOTAL),
    .HS_START (HS_START),
    .SCR_LIMIT(SCR_LIMIT),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fb_rd_en (fb_rd_en),
    .pixel    (pixel),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .h_cnt    (h_cnt),
    .line_addr(line_addr)
);

// File: tb/test_vga_scanout.sv
`timescale 1ns/1ps
module test_vga_scanout;
    localparam int H_TOTAL = 32, HS_START = 26, HS_END = 30, PAD_LEAD = 4;
    localparam int VIS_START = 3, VFP_START = 14, VS_START = 16, VS_END = 18;
    localparam int LINE_LEN = 16, LINE_MULT = 2;
    localparam int SCR_START = 40, SCR_LIMIT = 88, SCR_SIZE = 64, ADDR_W = 12;
    localparam int RUN_CYCLES = 2000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        fb_rdata = 8'd0;
    logic              fb_rd_en;
    logic [ADDR_W-1:0] fb_addr;
    logic [7:0]        pixel;
    logic              hsync_n;
    logic              vsync_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural model state
    int m_h = 0, m_line = 0, m_ph = 0, m_addr = SCR_START, m_vs = 1;
    int wrap_lines = 0, vs_falls = 0, prev_vs = 1;

    always #2.5 clk = ~clk;

    vga_scanout #(
        .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_END(HS_END), .PAD_LEAD(PAD_LEAD),
        .VIS_START(VIS_START), .VFP_START(VFP_START), .VS_START(VS_START), .VS_END(VS_END),
        .LINE_LEN(LINE_LEN), .LINE_MULT(LINE_MULT), .SCR_START(SCR_START),
        .SCR_LIMIT(SCR_LIMIT), .SCR_SIZE(SCR_SIZE), .ADDR_W(ADDR_W)
    ) i_vga_scanout (
        .clk(clk), .rst_n(rst_n), .fb_rdata(fb_rdata), .fb_rd_en(fb_rd_en),
        .fb_addr(fb_addr), .pixel(pixel), .hsync_n(hsync_n), .vsync_n(vsync_n)
    );

    function automatic logic [7:0] fbyte(input int a);
        return 8'((a * 37) + 5);
    endfunction

    // framebuffer with one cycle of read latency
    always @(posedge clk) fb_rdata <= fbyte(int'(fb_addr));

    // reference model, advanced on the same edge as the design
    always @(posedge clk) begin
        if (rst_n) begin
            if (m_h == H_TOTAL - 1) begin
                m_h = 0;
                m_vs = (m_ph != 3) ? 1 : 0;
                m_line = m_line + 1;
                case (m_ph)
                    0: if (m_line >= VIS_START) begin m_ph = 1; m_addr = SCR_START; end
                    1: if (m_line < VFP_START) begin
                           if (m_line % LINE_MULT == 0) begin
                               m_addr = m_addr + LINE_LEN;
                               if (m_addr >= SCR_LIMIT) m_addr = m_addr - SCR_SIZE;
                           end
                       end else m_ph = 2;
                    2: if (m_line >= VS_START) m_ph = 3;
                    default: if (m_line >= VS_END) begin m_line = 0; m_ph = 0; end
                endcase
            end else begin
                m_h = m_h + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (h=%0d line=%0d)", req, act, exp, m_h, m_line);
        end
    endtask

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        check("R1 hsync_n", int'(hsync_n), 1);
        check("R1 vsync_n", int'(vsync_n), 1);
        check("R1 pixel", int'(pixel), 0);
        check("R1 fb_rd_en", int'(fb_rd_en), 0);
        rst_n = 1'b1;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            int e_rd, e_pix, e_adr, k;
            @(negedge clk);
            // R2 horizontal sync window
            check("R2 hsync_n", int'(hsync_n), (m_h >= HS_START && m_h < HS_END) ? 0 : 1);
            // R3 R4 vertical sync follows the phase sequence one line late
            check("R4 vsync_n", int'(vsync_n), m_vs);
            if (prev_vs == 1 && m_vs == 0) vs_falls++;
            prev_vs = m_vs;
            // R10 request window
            e_rd = (m_ph == 1 && m_h >= PAD_LEAD - 1 && m_h < PAD_LEAD - 1 + LINE_LEN) ? 1 : 0;
            check("R10 fb_rd_en", int'(fb_rd_en), e_rd);
            if (e_rd == 1) begin
                k = m_h - (PAD_LEAD - 1);
                // R5 R6 R8 two halves of the line
                e_adr = (k < LINE_LEN / 2) ? (m_addr + k) : (m_addr + LINE_LEN / 2 + (k - LINE_LEN / 2));
                check("R8 fb_addr", int'(fb_addr), e_adr);
            end
            // R9 zero padding, R8 data one cycle after request
            if (m_ph == 1 && m_h >= PAD_LEAD && m_h < PAD_LEAD + LINE_LEN) begin
                e_pix = int'(fbyte(m_addr + m_h - PAD_LEAD));
                if (m_h == PAD_LEAD && m_addr == SCR_LIMIT - SCR_SIZE) wrap_lines++;
            end else begin
                e_pix = 0;
            end
            check("R9 pixel", int'(pixel), e_pix);
        end
        // R7 a wrapped line address was displayed (two lines per frame, three frames)
        check("R7 wrapped lines", (wrap_lines >= 2) ? 1 : 0, 1);
        // R3 number of vertical sync pulses
        check("R3 vsync pulses", vs_falls, RUN_CYCLES / (H_TOTAL * VS_END));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule